// File: doc/BRIEF.md
# First-Active-Lane Scalar Extractor

This combinational unit reduces a wide vector register to one scalar. It receives every lane of a 64-lane vector register as one flat 2048-bit bus, with 32 bits per lane, and a 64-bit lane execution mask. It returns the 32-bit value held by the lowest-numbered lane whose mask bit is set.

The mask only decides which lane is read. It never blocks the operation. When no lane is active, lane 0 is read, so the unit always delivers a defined scalar. The chosen lane index and a flag saying whether any lane was active are also brought out. The owner of the surrounding pipeline can use them to write a scalar register or to steer later logic.

A lowest-set-bit priority tree of logarithmic depth finds the lane. A parameter chooses how the lane word is then fetched: an indexed multiplexer driven by the tree, or an AND-OR gather driven by an isolated one-hot mask.

Top module: `first_lane_extract`

## Requirements
- R1: The data bus carries 64 lanes of 32 bits each. Lane i occupies bits [32*i+31 : 32*i].
- R2: When the mask is non-zero, the reported lane index is the smallest i with mask bit i set.
- R3: When the mask is all zeros, the reported lane index is 0 and the scalar equals lane 0's value.
- R4: The scalar output always equals the 32-bit value of the lane named by the lane index output.
- R5: The active flag is 1 exactly when at least one mask bit is set.
- R6: The values of lanes other than the selected one have no effect on any output. Mask bits above the lowest set bit have no effect on any output.
- R7: The outputs are a pure function of the present inputs, with no storage. Both lane-fetch structures (indexed and one-hot gather) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_data_i | input | 2048 | All lane values, lane 0 in the least significant 32 bits |
| exec_mask_i | input | 64 | Lane execution mask, bit i for lane i |
| scalar_o | output | 32 | Value copied from the selected lane |
| lane_idx_o | output | 6 | Index of the selected lane |
| any_active_o | output | 1 | High when the mask has any bit set |

## Verification
The bound checker tests every input combination that appears. For each one it confirms three things: the selected mask bit is set with no set bit below it, an empty mask yields index 0, and the flag and the scalar agree with the mask and the data at the reported index. Whether unselected lanes and upper mask bits truly have no influence can only be shown by the bench. It perturbs those inputs and compares before and after. The same holds for the agreement between the two fetch structures, which the bench shows with a second instance built with the one-hot gather.

// File: rtl/fle_pkg.sv
// Package: shared defaults and the result record for the first-active-lane
// extractor. Assumes lane counts are powers of two and at least 2.
package fle_pkg;
    localparam int FLE_LANES  = 64;
    localparam int FLE_LANE_W = 32;

    // Outcome of the lane search
    typedef struct packed {
        logic                         found;
        logic [$clog2(FLE_LANES)-1:0] lane;
    } fle_pick_t;
endpackage

// File: rtl/fle_prio_tree.sv
// Module: lowest-set-bit priority tree. Builds a heap-ordered binary tree of
// (valid, index) nodes; each internal node prefers its lower-lane child.
// Assumes N_LANES is a power of two. Index is forced to 0 when no bit is set.
module fle_prio_tree #(
    parameter int N_LANES = 64,
    localparam int IDX_W  = $clog2(N_LANES)
) (
    input  logic [N_LANES-1:0] mask_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   lane_o
);
    localparam int NODES = 2 * N_LANES - 1;
    localparam int FIRST_LEAF = N_LANES - 1;

    logic             node_v   [NODES];
    logic [IDX_W-1:0] node_idx [NODES];

    genvar k;
    generate
        for (k = 0; k < NODES; k++) begin : g_node
            if (k >= FIRST_LEAF) begin : g_leaf
                // Leaf: one mask bit, constant lane number
                assign node_v[k]   = mask_i[k - FIRST_LEAF];
                assign node_idx[k] = IDX_W'(k - FIRST_LEAF);
            end else begin : g_inner
                // Inner node: lower-lane child wins when it has a set bit
                assign node_v[k]   = node_v[2*k+1] | node_v[2*k+2];
                assign node_idx[k] = node_v[2*k+1] ? node_idx[2*k+1]
                                                   : node_idx[2*k+2];
            end
        end
    endgenerate

    // Root result with the empty-mask fallback to lane 0
    assign found_o = node_v[0];
    assign lane_o  = node_v[0] ? node_idx[0] : '0;
endmodule

// File: rtl/fle_onehot_isolate.sv
// Module: isolates the lowest set mask bit as a one-hot vector, using the
// two's-complement trick. An empty mask maps to a one-hot on lane 0.
module fle_onehot_isolate #(
    parameter int N_LANES = 64
) (
    input  logic [N_LANES-1:0] mask_i,
    output logic [N_LANES-1:0] onehot_o
);
    logic [N_LANES-1:0] lowest;

    // Keep only the lowest set bit
    assign lowest = mask_i & (~mask_i + N_LANES'(1));

    // Fallback to lane 0 when nothing is set
    always_comb begin
        onehot_o = lowest;
        if (mask_i == '0) onehot_o = N_LANES'(1);
    end
endmodule

// File: rtl/fle_lane_select.sv
// Module: fetches one lane word from the flat vector bus. ONEHOT_GATHER
// picks the structure: 0 = indexed multiplexer, 1 = AND-OR over a one-hot.
// Assumes the one-hot input has exactly one bit set when used.
module fle_lane_select #(
    parameter int N_LANES       = 64,
    parameter int LANE_W        = 32,
    parameter bit ONEHOT_GATHER = 1'b0,
    localparam int IDX_W        = $clog2(N_LANES)
) (
    input  logic [N_LANES*LANE_W-1:0] data_i,
    input  logic [IDX_W-1:0]          lane_i,
    input  logic [N_LANES-1:0]        onehot_i,
    output logic [LANE_W-1:0]         word_o
);
    generate
        if (ONEHOT_GATHER) begin : g_gather
            logic [IDX_W-1:0] unused_lane;
            assign unused_lane = lane_i;
            // OR together every lane masked by its one-hot bit
            always_comb begin
                word_o = '0;
                for (int i = 0; i < N_LANES; i++) begin
                    word_o |= data_i[i*LANE_W +: LANE_W] & {LANE_W{onehot_i[i]}};
                end
            end
        end else begin : g_index
            logic [N_LANES-1:0] unused_oh;
            assign unused_oh = onehot_i;
            // Indexed part-select of the chosen lane
            assign word_o = data_i[int'(lane_i)*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/first_lane_extract.sv
// Module: top of the first-active-lane extractor. Purely combinational:
// finds the lowest active lane (lane 0 if none) and copies its word out.
// Assumes N_LANES is a power of two, at least 2.
module first_lane_extract
    import fle_pkg::*;
#(
    parameter int N_LANES       = FLE_LANES,
    parameter int LANE_W        = FLE_LANE_W,
    parameter bit ONEHOT_GATHER = 1'b0,
    localparam int IDX_W        = $clog2(N_LANES)
) (
    input  logic [N_LANES*LANE_W-1:0] lane_data_i,
    input  logic [N_LANES-1:0]        exec_mask_i,
    output logic [LANE_W-1:0]         scalar_o,
    output logic [IDX_W-1:0]          lane_idx_o,
    output logic                      any_active_o
);
    logic               tree_found;
    logic [IDX_W-1:0]   tree_lane;
    logic [N_LANES-1:0] pick_onehot;

    fle_prio_tree #(.N_LANES(N_LANES)) u_tree (
        .mask_i  (exec_mask_i),
        .found_o (tree_found),
        .lane_o  (tree_lane)
    );

    fle_onehot_isolate #(.N_LANES(N_LANES)) u_iso (
        .mask_i   (exec_mask_i),
        .onehot_o (pick_onehot)
    );

    fle_lane_select #(
        .N_LANES       (N_LANES),
        .LANE_W        (LANE_W),
        .ONEHOT_GATHER (ONEHOT_GATHER)
    ) u_sel (
        .data_i   (lane_data_i),
        .lane_i   (tree_lane),
        .onehot_i (pick_onehot),
        .word_o   (scalar_o)
    );

    // Drive the index and flag outputs from the tree
    assign lane_idx_o   = tree_lane;
    assign any_active_o = tree_found;
endmodule

// File: rtl/first_lane_extract_chk.sv
// Module: assertion checker for first_lane_extract. The block has no clock,
// so every check is an immediate assertion re-evaluated when inputs change.
module first_lane_extract_chk #(
    parameter int N_LANES = 64,
    parameter int LANE_W  = 32,
    localparam int IDX_W  = $clog2(N_LANES)
) (
    input logic [N_LANES*LANE_W-1:0] lane_data_i,
    input logic [N_LANES-1:0]        exec_mask_i,
    input logic [LANE_W-1:0]         scalar_o,
    input logic [IDX_W-1:0]          lane_idx_o,
    input logic                      any_active_o
);
    // Check lane choice, fallback, flag and data copy
    always_comb begin
        logic below_hit;
        below_hit = 1'b0;
        for (int i = 0; i < N_LANES; i++) begin
            if (i < int'(lane_idx_o) && exec_mask_i[i]) below_hit = 1'b1;
        end
        AST_PICKED_BIT_SET: assert (!any_active_o || exec_mask_i[lane_idx_o]); // R2
        AST_NO_LOWER_ACTIVE: assert (!below_hit); // R2
        AST_EMPTY_LANE_ZERO: assert (exec_mask_i != '0 || lane_idx_o == '0); // R3
        AST_FLAG_MATCHES_MASK: assert (any_active_o == (exec_mask_i != '0)); // R5
        AST_SCALAR_FROM_LANE: assert (scalar_o == lane_data_i[int'(lane_idx_o)*LANE_W +: LANE_W]); // R4
    end
endmodule

bind first_lane_extract first_lane_extract_chk #(
    .N_LANES (N_LANES),
    .LANE_W  (LANE_W)
) u_chk (
    .lane_data_i  (lane_data_i),
    .exec_mask_i  (exec_mask_i),
    .scalar_o     (scalar_o),
    .lane_idx_o   (lane_idx_o),
    .any_active_o (any_active_o)
);

// File: tb/test_first_lane_extract.sv
// Bench: sweeps masks over the default 64x32 configuration and compares both
// fetch structures against expectations computed in the bench.
module test_first_lane_extract;
    localparam int N = 64;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N*W-1:0] data;
    logic [N-1:0]   mask;
    logic [W-1:0]   sc_a, sc_b;
    logic [5:0]     ix_a, ix_b;
    logic           any_a, any_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    first_lane_extract #(.ONEHOT_GATHER(1'b0)) i_first_lane_extract (
        .lane_data_i(data), .exec_mask_i(mask),
        .scalar_o(sc_a), .lane_idx_o(ix_a), .any_active_o(any_a));

    first_lane_extract #(.ONEHOT_GATHER(1'b1)) i_first_lane_extract_oh (
        .lane_data_i(data), .exec_mask_i(mask),
        .scalar_o(sc_b), .lane_idx_o(ix_b), .any_active_o(any_b));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Fill every lane with a distinct word derived from a seed (R1 layout)
    task automatic fill(input int seed);
        for (int i = 0; i < N; i++)
            data[i*W +: W] = {8'(i), 24'(seed * 7919 + i * 131 + 5)};
    endtask

    function automatic int exp_lane(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return 0;
    endfunction

    // Apply inputs on the falling edge, sample 1 ns later, compare all outputs
    task automatic apply_and_check(input logic [N-1:0] m, input string tag);
        int el;
        logic [W-1:0] ew;
        @(negedge clk);
        mask = m;
        #1;
        el = exp_lane(m);
        ew = data[el*W +: W];
        check(ix_a == 6'(el), {tag, " R2/R3 index"}, ix_a, el);
        check(sc_a == ew, {tag, " R4 scalar"}, sc_a, ew);
        check(any_a == (m != '0), {tag, " R5 flag"}, any_a, m != '0);
        check(sc_b == sc_a && ix_b == ix_a && any_b == any_a,
              {tag, " R7 gather agrees"}, sc_b, sc_a);
    endtask

    initial begin
        data = '0;
        mask = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle inputs: all zero outputs
        check(sc_a == '0 && ix_a == '0 && any_a == 1'b0, "R3 idle state", sc_a, 0);

        fill(1);
        apply_and_check('0, "empty mask R3");
        check(sc_a == {8'd0, 24'(1 * 7919 + 5)}, "R1 lane0 layout", sc_a, {8'd0, 24'(7924)});

        for (int p = 0; p < N; p++) begin
            fill(p + 2);
            apply_and_check(N'(1) << p, "single bit R2");
        end

        apply_and_check('1, "all ones R2");

        // R6: upper mask bits do not change the output
        for (int p = 0; p < N; p++) begin
            logic [W-1:0] ref_sc;
            apply_and_check(N'(1) << p, "R6 base");
            ref_sc = sc_a;
            apply_and_check(~((N'(1) << p) - N'(1)), "R6 upper bits");
            check(sc_a == ref_sc, "R6 upper mask bits ignored", sc_a, ref_sc);
        end

        // R6: rewriting unselected lanes leaves the scalar alone
        for (int t = 0; t < 40; t++) begin
            logic [N-1:0] m;
            logic [W-1:0] ref_sc;
            int el;
            m = {$urandom, $urandom} & {$urandom, $urandom};
            fill(t + 100);
            apply_and_check(m, "R6 base");
            ref_sc = sc_a;
            el = exp_lane(m);
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if (i != el) data[i*W +: W] = $urandom;
            #1;
            check(sc_a == ref_sc && sc_b == ref_sc, "R6 other lanes ignored", sc_a, ref_sc);
        end

        // Random masks, dense and sparse (R7 outputs follow inputs at once)
        for (int t = 0; t < 300; t++) begin
            logic [N-1:0] m;
            m = {$urandom, $urandom};
            if (t % 3 == 1) m = m & {$urandom, $urandom} & {$urandom, $urandom};
            if (t % 3 == 2) m = m & (N'(1) << (t % N)) | (N'(1) << (63 - t % N));
            fill(t + 500);
            apply_and_check(m, "random R7");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hang counts as a failed check
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule